// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous 8K x 8 static RAM. The RAM has one active-low enable, one active-high enable, an active-low output enable and an active-low write enable. The host presents a read or write request as a single-cycle pulse while the ready output is high. The block then drives the RAM pins through a sequence whose length in clock cycles is derived from nanosecond minima. When the access ends it returns a one-cycle acknowledge, and for reads the captured byte comes with it.

Each nanosecond minimum is a parameter. It becomes a cycle count as ceil(min_ns / clock_period_ns), and the count is never less than one. A write keeps write enable low for the longest of the cycle-time, write-pulse, enable-to-end and data-setup counts. A read keeps output enable low for the longest of the cycle-time, address-access, enable-access and output-enable-access counts. After a read, the block waits out the time the RAM needs to release the bus before it accepts another request. The data bus is split into an outgoing byte, an incoming byte and a drive enable. The pad buffer that combines them lies outside this block.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is high and after it is released with no request, the outputs are: mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, host_rdy=1, host_ack=0.
- R2: The RAM is selected (mem_ce1_n=0 and mem_ce2=1) only while an access is in progress. Otherwise both enables are in the deselect state, and the two enables always change together.
- R3: A write accepted at a clock edge holds mem_we_n low, with the RAM selected and mem_oe_n high, for exactly WR = max(ceil(T_WC), ceil(T_WP), ceil(T_CW), ceil(T_DS)) cycles starting at the next cycle. With the default 20 ns clock this is 2 cycles.
- R4: mem_dq_oe is high exactly while mem_we_n is low. During that time mem_dq_out carries the accepted write byte, and mem_oe_n is high.
- R5: A read accepted at a clock edge holds mem_oe_n low, with the RAM selected and mem_we_n high and mem_dq_oe low, for exactly RD = max(ceil(T_RC), ceil(T_AA), ceil(T_ACE), ceil(T_OE)) cycles. With the defaults this is 2 cycles.
- R6: host_ack is high for exactly one cycle, which is the cycle after the strobes are released. For a read, host_rdata in that cycle equals mem_dq_in as sampled at the edge that released the strobes.
- R7: host_rdy is high only when no access is running. It rises in the acknowledge cycle of a write. After a read it stays low for GAP = max(ceil(T_HZOE), ceil(T_HZCE)) further cycles (1 with the defaults).
- R8: mem_addr holds the accepted address for the whole time the RAM is selected.
- R9: A request presented while host_rdy is low is ignored: it starts no access and produces no acknowledge. An access starts only at an edge where both host_req and host_rdy are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request, taken when host_rdy is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdy | output | 1 | Ready to accept a request |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 8 | Read byte, valid with host_ack after a read |
| mem_addr | output | 13 | RAM address |
| mem_ce1_n | output | 1 | RAM enable, active low |
| mem_ce2 | output | 1 | RAM enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the RAM |
| mem_dq_in | input | 8 | Byte returned from the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
In one cycle, the completion of an access (acknowledge, read capture and strobe release) can coincide with the host presenting its next request. The bench provokes this by holding host_req high from the acknowledge cycle onward. After a write, the request must be taken at the next edge with no deselected gap other than the acknowledge cycle. After a read, the request must be ignored through the bus-release gap and taken only once host_rdy returns. A cycle-by-cycle reference model compares every RAM pin and host output. It also checks that the number of acknowledges equals the number of accepted requests.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2
  } ctl_state_e;

  // ceil(t_ns / clk_ns), never below one cycle
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W   = 2,
  parameter int WR_CYC  = 2,
  parameter int RD_CYC  = 2,
  parameter int GAP_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             tmr_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             host_rdy,
  output logic             host_ack,
  output logic             mem_ce1_n,
  output logic             mem_ce2,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_dq_oe
);

  ctl_state_e state_q;
  logic       op_wr_q;
  logic       finish;
  logic       gap_done;

  assign accept   = (state_q == ST_IDLE) && host_req;
  assign finish   = (state_q == ST_ACT) && tmr_last;
  assign gap_done = (state_q == ST_GAP) && tmr_last;
  assign capture  = finish && !op_wr_q;
  assign tmr_load = accept || finish;

  always_comb begin
    if (accept) begin
      tmr_val = host_we ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
    end else begin
      tmr_val = CNT_W'(GAP_CYC);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_wr_q   <= 1'b0;
      host_rdy  <= 1'b1;
      host_ack  <= 1'b0;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q   <= ST_ACT;
            op_wr_q   <= host_we;
            host_rdy  <= 1'b0;
            mem_ce1_n <= 1'b0;
            mem_ce2   <= 1'b1;
            mem_oe_n  <= host_we;
            mem_we_n  <= !host_we;
            mem_dq_oe <= host_we;
          end
        end
        ST_ACT: begin
          if (finish) begin
            host_ack  <= 1'b1;
            mem_ce1_n <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            if (op_wr_q) begin
              state_q  <= ST_IDLE;
              host_rdy <= 1'b1;
            end else begin
              state_q  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            state_q  <= ST_IDLE;
            host_rdy <= 1'b1;
          end
        end
        default: begin
          state_q  <= ST_IDLE;
          host_rdy <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] host_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= host_addr;
      mem_dq_out <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (capture) begin
      host_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_WC_NS   = 35,
  parameter int T_WP_NS   = 20,
  parameter int T_CW_NS   = 25,
  parameter int T_DS_NS   = 15,
  parameter int T_RC_NS   = 35,
  parameter int T_AA_NS   = 35,
  parameter int T_ACE_NS  = 35,
  parameter int T_OE_NS   = 15,
  parameter int T_HZOE_NS = 12,
  parameter int T_HZCE_NS = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rdy,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int WR_CYC = max_of(
    max_of(ns_to_cycles(T_WC_NS, CLK_NS), ns_to_cycles(T_WP_NS, CLK_NS)),
    max_of(ns_to_cycles(T_CW_NS, CLK_NS), ns_to_cycles(T_DS_NS, CLK_NS)));
  localparam int RD_CYC = max_of(
    max_of(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_AA_NS, CLK_NS)),
    max_of(ns_to_cycles(T_ACE_NS, CLK_NS), ns_to_cycles(T_OE_NS, CLK_NS)));
  localparam int GAP_CYC = max_of(ns_to_cycles(T_HZOE_NS, CLK_NS),
                                  ns_to_cycles(T_HZCE_NS, CLK_NS));
  localparam int CNT_W = $clog2(max_of(max_of(WR_CYC, RD_CYC), GAP_CYC) + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             accept;
  logic             capture;

  sram_ctl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_ctl_fsm #(
    .CNT_W   (CNT_W),
    .WR_CYC  (WR_CYC),
    .RD_CYC  (RD_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .host_req  (host_req),
    .host_we   (host_we),
    .tmr_last  (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .host_rdy  (host_rdy),
    .host_ack  (host_ack),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_ctl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .capture    (capture),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .host_rdata (host_rdata)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int CLK_NS   = 20,
  parameter int T_WC_NS  = 35,
  parameter int T_WP_NS  = 20,
  parameter int T_CW_NS  = 25,
  parameter int T_DS_NS  = 15,
  parameter int T_RC_NS  = 35,
  parameter int T_AA_NS  = 35,
  parameter int T_ACE_NS = 35,
  parameter int T_OE_NS  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              host_req,
  input logic              host_rdy,
  input logic              host_ack,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam int WR_LEN = max_of(
    max_of(ns_to_cycles(T_WC_NS, CLK_NS), ns_to_cycles(T_WP_NS, CLK_NS)),
    max_of(ns_to_cycles(T_CW_NS, CLK_NS), ns_to_cycles(T_DS_NS, CLK_NS)));
  localparam int RD_LEN = max_of(
    max_of(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_AA_NS, CLK_NS)),
    max_of(ns_to_cycles(T_ACE_NS, CLK_NS), ns_to_cycles(T_OE_NS, CLK_NS)));

  logic [15:0] we_run;
  logic [15:0] oe_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? 16'd0 : we_run + 16'd1;
      oe_run <= mem_oe_n ? 16'd0 : oe_run + 16'd1;
    end
  end

  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    host_rdy |-> (mem_ce1_n && !mem_ce2));

  assert_enables_paired_R2: assert property (@(posedge clk) disable iff (rst)
    mem_ce1_n == !mem_ce2);

  assert_we_len_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run == 16'(WR_LEN)));

  assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  assert_rd_len_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_run == 16'(RD_LEN)));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  assert_gap_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> !host_rdy);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && !$past(mem_ce1_n)) |-> $stable(mem_addr));

  assert_start_on_accept_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce1_n) |-> ($past(host_rdy) && $past(host_req)));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .CLK_NS   (CLK_NS),
  .T_WC_NS  (T_WC_NS),
  .T_WP_NS  (T_WP_NS),
  .T_CW_NS  (T_CW_NS),
  .T_DS_NS  (T_DS_NS),
  .T_RC_NS  (T_RC_NS),
  .T_AA_NS  (T_AA_NS),
  .T_ACE_NS (T_ACE_NS),
  .T_OE_NS  (T_OE_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_req  (host_req),
  .host_rdy  (host_rdy),
  .host_ack  (host_ack),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/test_sram_async_ctl.sv
module test_sram_async_ctl;

  localparam int CLK_NS = 20;

  logic        clk;
  logic        rst;
  logic        host_req;
  logic        host_we;
  logic [12:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_rdy;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic [12:0] mem_addr;
  logic        mem_ce1_n;
  logic        mem_ce2;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;
  logic        mem_dq_oe;

  int checks = 0;
  int failures = 0;
  int cyc_cnt = 0;
  int reqs = 0;
  int acks_seen = 0;

  sram_async_ctl #(.CLK_NS(CLK_NS)) i_sram_async_ctl (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdy(host_rdy),
    .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int cyc(input int t_ns);
    int c;
    c = (t_ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int e_wr;
  int e_rd;
  int e_gap;
  initial begin
    e_wr  = mx(mx(cyc(35), cyc(20)), mx(cyc(25), cyc(15)));
    e_rd  = mx(mx(cyc(35), cyc(35)), mx(cyc(35), cyc(15)));
    e_gap = mx(cyc(12), cyc(15));
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h at t=%0t", rq, what, act, exp, $time);
    end
  endtask

  // external RAM model, driven only by the DUT pins
  logic [7:0] dev_mem [int];
  always @(negedge clk) begin
    if (!mem_ce1_n && mem_ce2 && !mem_we_n && mem_dq_oe)
      dev_mem[int'(mem_addr)] = mem_dq_out;
    if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
      mem_dq_in = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'h00;
  end

  // cycle-level reference model
  int         ph = 0;   // 0 idle, 1 access, 2 release gap
  int         cnt = 0;
  bit         m_wr = 0;
  logic [12:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  bit         m_ack = 0;
  bit         m_ack_rd = 0;
  logic [7:0]  m_rdata = '0;
  logic [7:0]  ref_mem [int];

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; cnt = 0; m_ack = 0; m_ack_rd = 0;
    end else begin
      m_ack = 0;
      m_ack_rd = 0;
      case (ph)
        0: if (host_req) begin
          ph = 1; m_wr = host_we; m_addr = host_addr; m_data = host_wdata;
          cnt = host_we ? e_wr : e_rd;
        end
        1: begin
          cnt--;
          if (cnt == 0) begin
            m_ack = 1;
            if (m_wr) begin
              ref_mem[int'(m_addr)] = m_data;
              ph = 0;
            end else begin
              m_ack_rd = 1;
              m_rdata = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : 8'h00;
              ph = 2;
              cnt = e_gap;
            end
          end
        end
        default: begin
          cnt--;
          if (cnt == 0) ph = 0;
        end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit sel;
      sel = (ph == 1);
      chk("R2", "mem_ce1_n", 32'(mem_ce1_n), 32'(!sel));
      chk("R2", "mem_ce2",   32'(mem_ce2),   32'(sel));
      chk("R3", "mem_we_n",  32'(mem_we_n),  32'(!(sel && m_wr)));
      chk("R5", "mem_oe_n",  32'(mem_oe_n),  32'(!(sel && !m_wr)));
      chk("R4", "mem_dq_oe", 32'(mem_dq_oe), 32'(sel && m_wr));
      if (sel && m_wr) chk("R4", "mem_dq_out", 32'(mem_dq_out), 32'(m_data));
      if (sel) chk("R8", "mem_addr", 32'(mem_addr), 32'(m_addr));
      chk("R7", "host_rdy", 32'(host_rdy), 32'(ph == 0));
      chk("R6", "host_ack", 32'(host_ack), 32'(m_ack));
      if (m_ack_rd) chk("R6", "host_rdata", 32'(host_rdata), 32'(m_rdata));
      if (host_ack) acks_seen++;
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // called at a falling edge; waits for ready, then a one-cycle pulse
  task automatic issue(input bit we, input logic [12:0] a, input logic [7:0] d);
    while (!host_rdy) @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    reqs++;
  endtask

  // raises the request at once and holds it until it is taken (R9)
  task automatic issue_hold(input bit we, input logic [12:0] a, input logic [7:0] d);
    bit taken;
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    taken = 1'b0;
    while (!taken) begin
      taken = host_rdy;
      @(negedge clk);
    end
    host_req = 1'b0;
    reqs++;
  endtask

  task automatic wait_ack;
    while (!host_ack) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mem_ce1_n", 32'(mem_ce1_n), 32'd1);
    chk("R1", "mem_ce2",   32'(mem_ce2),   32'd0);
    chk("R1", "mem_oe_n",  32'(mem_oe_n),  32'd1);
    chk("R1", "mem_we_n",  32'(mem_we_n),  32'd1);
    chk("R1", "mem_dq_oe", 32'(mem_dq_oe), 32'd0);
    chk("R1", "host_rdy",  32'(host_rdy),  32'd1);
    chk("R1", "host_ack",  32'(host_ack),  32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset rdy", 32'(host_rdy), 32'd1);

    // boundary addresses and data patterns (R3, R4)
    issue(1'b1, 13'h0000, 8'hA5);
    issue(1'b1, 13'h1FFF, 8'hFF);
    issue(1'b1, 13'h0AAA, 8'h00);
    issue(1'b1, 13'h1555, 8'h5A);
    // reads back, including an unwritten location (R5, R6)
    issue(1'b0, 13'h0000, 8'h00);
    issue(1'b0, 13'h1FFF, 8'h00);
    issue(1'b0, 13'h0AAA, 8'h00);
    issue(1'b0, 13'h1234, 8'h00);

    // request lands in the acknowledge cycle of a write (R7)
    issue(1'b1, 13'h0100, 8'h11);
    wait_ack;
    issue_hold(1'b1, 13'h0101, 8'h22);
    // request held through the acknowledge and gap of a read (R7, R9)
    issue(1'b0, 13'h0100, 8'h00);
    wait_ack;
    issue_hold(1'b0, 13'h0101, 8'h00);
    wait_ack;
    issue_hold(1'b1, 13'h0102, 8'h33);

    // mixed pattern
    for (int i = 0; i < 24; i++) begin
      issue(1'b1, 13'((i * 397) % 8192), 8'((i * 37) + 3));
      if (i % 3 == 0) issue(1'b0, 13'(((i - 1) * 397 + 8192) % 8192), 8'h00);
    end
    for (int i = 0; i < 24; i++) begin
      issue_hold(1'b0, 13'((i * 397) % 8192), 8'h00);
    end

    repeat (8) @(negedge clk);
    chk("R9", "ack count equals accepted requests", 32'(acks_seen), 32'(reqs));
    chk("R2", "deselected when drained", 32'(mem_ce1_n), 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule